// File: doc/BRIEF.md
# SEC-DED Hamming (8,4) Decoder

This block recovers a 4-bit message from an 8-bit protected word: a Hamming (7,4) codeword with one extra bit that holds even parity over the other seven. It computes a 3-bit syndrome and checks parity across the whole word. With those two results it sorts each word into one of four cases: clean, a single error it can correct, a flip of the extra parity bit alone, or a double error it can only detect.

The result is one recovered message and two flags. The first flag rises on any detected error. The second rises only when the error was fixed. All three outputs are registered. A synchronous, active-high reset clears them. The width follows from one parameter, the number of Hamming check bits. The default value gives the 8-bit word and the 4-bit message.

Top module: `hamming_secded_dec`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs after that edge are `data_o` = 0, `err_o` = 0 and `fix_o` = 0.
- R2: Every output depends only on the `code_i` value sampled at the previous rising edge. This is a latency of exactly one cycle.
- R3: Suppose exactly one bit among `code_i[6:0]` is inverted relative to a valid word. Then `data_o` equals the original message, `err_o` = 1 and `fix_o` = 1.
- R4: Suppose only `code_i[7]` is inverted relative to a valid word. Then `data_o` equals the message unchanged, `err_o` = 1 and `fix_o` = 1.
- R5: For a valid word, `err_o` = 0, `fix_o` = 0 and `data_o` equals the message.
- R6: Suppose exactly two bits of the word are inverted relative to a valid word. Then `err_o` = 1 and `fix_o` = 0. `data_o` carries the received message bits `{code_i[6], code_i[5], code_i[4], code_i[2]}` with no change.
- R7: `fix_o` is never high while `err_o` is low.
- R8: Bit layout of a valid word:
  - `code_i[k]` holds Hamming position k+1.
  - Message bits m0..m3 sit in `code_i[2]`, `code_i[4]`, `code_i[5]` and `code_i[6]`.
  - `code_i[0]` is the XOR of positions 3, 5 and 7.
  - `code_i[1]` is the XOR of positions 3, 6 and 7.
  - `code_i[3]` is the XOR of positions 5, 6 and 7.
  - `code_i[7]` makes the XOR of all eight bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 8 | Received protected word |
| data_o | output | 4 | Recovered message, registered |
| err_o | output | 1 | An error was detected (single or double), registered |
| fix_o | output | 1 | The detected error was corrected, registered |

## Verification
Each word presented to `code_i` produces its message and both flags exactly one rising edge later. A reset produces its all-zero outputs one edge after it is sampled. The bench drives a word on a falling edge and queues the expected result for it. It compares that result at the next falling edge, after the sampling edge has passed. In this way every comparison lands in the single cycle where the result is due, and a result that arrives early or late shows up as a miscompare. The expected values come from the kind of corruption the bench applied: none, one flip at each of the eight positions, or every pair of flips. They are built for all sixteen messages.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    CLS_CLEAN   = 2'd0,
    CLS_SINGLE  = 2'd1,
    CLS_OVERALL = 2'd2,
    CLS_DOUBLE  = 2'd3
  } err_cls_e;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // Hamming position (1-based) of the j-th message bit
  function automatic int data_pos(input int j);
    int n;
    int r;
    n = 0;
    r = 0;
    for (int p = 1; p < 256; p++) begin
      if (!is_pow2(p)) begin
        if (n == j && r == 0) r = p;
        n++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
  parameter int PAR_W = 3
) (
  input  logic [(2**PAR_W)-1:0] code_i,
  output logic [PAR_W-1:0]      syn_o,
  output logic                  par_ok_o
);
  localparam int CODE_W = 2 ** PAR_W;

  for (genvar i = 0; i < PAR_W; i++) begin : g_chk
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int p = 1; p < CODE_W; p++) begin
        if (((p >> i) & 1) == 1) acc = acc ^ code_i[p-1];
      end
    end
    assign syn_o[i] = acc;
  end

  assign par_ok_o = ~(^code_i);

endmodule

// File: rtl/secded_correct.sv
module secded_correct
  import secded_pkg::*;
#(
  parameter int PAR_W = 3
) (
  input  logic [(2**PAR_W)-PAR_W-2:0] raw_data_i,
  input  logic [PAR_W-1:0]            syn_i,
  input  logic                        par_ok_i,
  output logic [(2**PAR_W)-PAR_W-2:0] data_o,
  output err_cls_e                    cls_o
);
  localparam int CODE_W = 2 ** PAR_W;
  localparam int DATA_W = CODE_W - PAR_W - 1;

  logic syn_zero;
  assign syn_zero = (syn_i == '0);

  for (genvar j = 0; j < DATA_W; j++) begin : g_fix
    localparam int POS = data_pos(j);
    assign data_o[j] = raw_data_i[j] ^ (!par_ok_i && (syn_i == PAR_W'(POS)));
  end

  always_comb begin
    if (par_ok_i) cls_o = syn_zero ? CLS_CLEAN : CLS_DOUBLE;
    else          cls_o = syn_zero ? CLS_OVERALL : CLS_SINGLE;
  end

endmodule

// File: rtl/hamming_secded_dec.sv
module hamming_secded_dec
  import secded_pkg::*;
#(
  parameter int PAR_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [(2**PAR_W)-1:0]       code_i,
  output logic [(2**PAR_W)-PAR_W-2:0] data_o,
  output logic                        err_o,
  output logic                        fix_o
);
  localparam int CODE_W = 2 ** PAR_W;
  localparam int DATA_W = CODE_W - PAR_W - 1;

  logic [PAR_W-1:0]  syn;
  logic              par_ok;
  logic [DATA_W-1:0] raw_data;
  logic [DATA_W-1:0] corr_data;
  err_cls_e          cls;

  for (genvar j = 0; j < DATA_W; j++) begin : g_raw
    localparam int POS = data_pos(j);
    assign raw_data[j] = code_i[POS-1];
  end

  secded_syndrome #(.PAR_W(PAR_W)) u_syn (
    .code_i   (code_i),
    .syn_o    (syn),
    .par_ok_o (par_ok)
  );

  secded_correct #(.PAR_W(PAR_W)) u_corr (
    .raw_data_i (raw_data),
    .syn_i      (syn),
    .par_ok_i   (par_ok),
    .data_o     (corr_data),
    .cls_o      (cls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      err_o  <= 1'b0;
      fix_o  <= 1'b0;
    end else begin
      data_o <= corr_data;
      err_o  <= (cls != CLS_CLEAN);
      fix_o  <= (cls == CLS_SINGLE) || (cls == CLS_OVERALL);
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (data_o == '0) && !err_o && !fix_o); // R1

  AST_FIX_NEEDS_ERR: assert property (@(posedge clk) disable iff (rst)
    fix_o |-> err_o); // R7

  AST_CLEAN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (syn == '0 && par_ok) |=> !err_o && !fix_o && (data_o == $past(raw_data))); // R5

  AST_DOUBLE_NO_FIX: assert property (@(posedge clk) disable iff (rst)
    (syn != '0 && par_ok) |=> err_o && !fix_o && (data_o == $past(raw_data))); // R6

  AST_SINGLE_FIXED: assert property (@(posedge clk) disable iff (rst)
    (!par_ok) |=> err_o && fix_o); // R3

  AST_OVERALL_PASS: assert property (@(posedge clk) disable iff (rst)
    (syn == '0 && !par_ok) |=> (data_o == $past(raw_data))); // R4

endmodule

// File: tb/hamming_secded_dec_tb_top.sv
module hamming_secded_dec_tb_top;

  typedef struct {
    logic [3:0] d;
    logic       e;
    logic       f;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] code = 8'h00;
  logic [3:0] data_o;
  logic       err_o;
  logic       fix_o;

  int vectors = 0;
  int miscompares = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  hamming_secded_dec dut_i (
    .clk    (clk),
    .rst    (rst),
    .code_i (code),
    .data_o (data_o),
    .err_o  (err_o),
    .fix_o  (fix_o)
  );

  // R8 layout, built behaviourally
  function automatic logic [7:0] encode(input logic [3:0] m);
    logic [7:0] c;
    c = '0;
    c[2] = m[0]; c[4] = m[1]; c[5] = m[2]; c[6] = m[3];
    for (int p = 1; p <= 7; p++) begin
      if (p != 1 && p != 2 && p != 4) begin
        if ((p & 1) != 0) c[0] ^= c[p-1];
        if ((p & 2) != 0) c[1] ^= c[p-1];
        if ((p & 4) != 0) c[3] ^= c[p-1];
      end
    end
    c[7] = ^c[6:0];
    return c;
  endfunction

  function automatic logic [3:0] raw_msg(input logic [7:0] c);
    return {c[6], c[5], c[4], c[2]};
  endfunction

  task automatic check_pending();
    exp_t x;
    if (q.size() == 0) return;
    x = q.pop_front();
    vectors++;
    if (data_o !== x.d || err_o !== x.e || fix_o !== x.f) begin
      miscompares++;
      $display("FAIL %s (R2 timing): got data=%h err=%b fix=%b, expected data=%h err=%b fix=%b",
               x.tag, data_o, err_o, fix_o, x.d, x.e, x.f);
    end
    if (fix_o === 1'b1 && err_o !== 1'b1) begin
      miscompares++;
      $display("FAIL R7: got fix=%b err=%b, expected err=1 whenever fix=1", fix_o, err_o);
    end
  endtask

  task automatic apply(input logic [7:0] c, input logic r, input logic [3:0] ed,
                       input logic ee, input logic ef, input string tag);
    exp_t x;
    @(negedge clk);
    check_pending();
    code = c;
    rst  = r;
    x.d = ed; x.e = ee; x.f = ef; x.tag = tag;
    q.push_back(x);
  endtask

  initial begin
    apply(8'hFF, 1'b1, 4'h0, 1'b0, 1'b0, "R1 reset");
    apply(8'h5A, 1'b1, 4'h0, 1'b0, 1'b0, "R1 reset");
    // clean words for every message
    for (int m = 0; m < 16; m++)
      apply(encode(4'(m)), 1'b0, 4'(m), 1'b0, 1'b0, "R5/R8 clean");
    // one flip at each position
    for (int m = 0; m < 16; m++) begin
      for (int b = 0; b < 8; b++) begin
        if (b < 7) apply(encode(4'(m)) ^ (8'h01 << b), 1'b0, 4'(m), 1'b1, 1'b1, "R3 single");
        else       apply(encode(4'(m)) ^ 8'h80, 1'b0, 4'(m), 1'b1, 1'b1, "R4 overall bit");
      end
    end
    // reset in the middle of erroneous traffic
    apply(encode(4'hA) ^ 8'h03, 1'b1, 4'h0, 1'b0, 1'b0, "R1 reset mid-run");
    // every pair of flips
    for (int m = 0; m < 16; m++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = a + 1; b < 8; b++) begin
          logic [7:0] w;
          w = encode(4'(m)) ^ (8'h01 << a) ^ (8'h01 << b);
          apply(w, 1'b0, raw_msg(w), 1'b1, 1'b0, "R6 double");
        end
      end
    end
    // back to back: clean right after double, checks R2 per cycle
    apply(encode(4'h3), 1'b0, 4'h3, 1'b0, 1'b0, "R5 after double");
    apply(encode(4'hC) ^ 8'h10, 1'b0, 4'hC, 1'b1, 1'b1, "R3 after clean");
    @(negedge clk);
    check_pending();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    miscompares++;
    $display("FAIL watchdog: got no completion, expected end of run");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule